// File: doc/BRIEF.md
# Reset Cause Register

This block holds a small bit vector that tells software which source brought about the latest reset. Each bit stands for one reset source: the external cold pin, a cold request from the configuration controller, the watchdog, a warm request, or one of the software-started reset kinds. The reset sequencer feeds the block per-source cold request levels, a one-cycle pulse when a cold reset finishes, and a one-cycle pulse with a source mask when a warm reset finishes.

Cold and warm completions update the vector in different ways. While cold requests are active, the block keeps track of the source or sources that dropped their request most recently. When the cold reset finishes, that set replaces the whole vector. A warm completion adds its source bits and leaves every other bit as it was. Software reads the vector at once. It clears bits by writing ones to them.

Only the power-on reset clears the register. Warm resets never clear it.

Top module: `reset_cause_reg`

## Requirements
- R1: After power-on reset (`por_n` low), `rdata` is all zeros.
- R2: On a cycle with `cold_done` high, the register takes the value of the last recorded cold-request deassertion set. Every bit outside that set is cleared.
- R3: A cold-request deassertion is a 1-to-0 change of a `cold_req` bit. When requests overlap, the sources that deassert in the latest cycle that had any deassertion win. Sources that deassert together in that cycle are all recorded. A deassertion seen at the same clock edge as `cold_done` counts as the latest.
- R4: On a cycle with `warm_done` high and `cold_done` low, the `warm_src` bits are set to 1 and no other bit is cleared.
- R5: A write (`wr_en` high) clears each register bit `i` with `wdata[i]` = 1. Bits with `wdata[i]` = 0 are unchanged.
- R6: When a warm set and a write clear hit the same bit in the same cycle, the bit ends up as 1.
- R7: `cold_done` overrides any warm completion or write in the same cycle. The result is the cold value alone.
- R8: `rdata` shows the current register with no added cycle. Bits `DW-1` down to `NSRC` always read 0.
- R9: In a cycle with no completion pulse and no write of a 1, the register holds its value.
- R10: A cold completion with no cold deassertion since the previous cold completion (or since power-on) leaves the register at zero. Each completion uses up the recorded set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cold_req | input | NSRC | Per-source cold reset request levels |
| cold_done | input | 1 | One-cycle pulse: cold reset finished |
| warm_done | input | 1 | One-cycle pulse: warm reset finished |
| warm_src | input | NSRC | Source mask of the finished warm reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | DW | Write data; a 1 clears the matching bit |
| rdata | output | DW | Current register value, upper bits zero |

## Verification
If the recorded deassertion set is wrong, the error stays hidden until the next cold completion. From the cycle after that pulse, every read shows a wrong bit pattern. If the register itself is wrong, `rdata` shows it in the same cycle, because the read path adds no latency. A stale set that is not used up after a completion can only be seen on a second completion that has no new deassertion, so the sweeps include that case. The set-wins rule is exercised by applying every warm mask against every write mask from every starting value. The ordering rule is exercised by dropping each mask pair in two stages.

// File: rtl/reset_cause_reg.sv
module reset_cause_reg #(
  parameter int NSRC = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NSRC-1:0] cold_req,
  input  logic            cold_done,
  input  logic            warm_done,
  input  logic [NSRC-1:0] warm_src,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);

  logic [NSRC-1:0] req_q, last_q, cause_q;
  logic [NSRC-1:0] fall, cold_val, clr, set, nxt;

  assign fall     = req_q & ~cold_req;
  assign cold_val = (|fall) ? fall : last_q;
  assign clr      = wr_en ? wdata[NSRC-1:0] : '0;
  assign set      = warm_done ? warm_src : '0;
  assign nxt      = cold_done ? cold_val : ((cause_q & ~clr) | set);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      req_q   <= '0;
      last_q  <= '0;
      cause_q <= '0;
    end else begin
      req_q   <= cold_req;
      cause_q <= nxt;
      if (cold_done)  last_q <= '0;
      else if (|fall) last_q <= fall;
    end
  end

  generate
    if (DW > NSRC) begin : g_pad
      assign rdata = {{(DW-NSRC){1'b0}}, cause_q};
    end else begin : g_nopad
      assign rdata = cause_q;
    end
  endgenerate

endmodule

module reset_cause_reg_chk #(
  parameter int NSRC = 8,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            por_n,
  input logic [NSRC-1:0] cold_req,
  input logic            cold_done,
  input logic            warm_done,
  input logic [NSRC-1:0] warm_src,
  input logic            wr_en,
  input logic [DW-1:0]   wdata,
  input logic [DW-1:0]   rdata
);

  logic [NSRC-1:0] prev_req, seen_q, seen_now;

  assign seen_now = seen_q | (prev_req & ~cold_req);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      prev_req <= '0;
      seen_q   <= '0;
    end else begin
      prev_req <= cold_req;
      seen_q   <= cold_done ? '0 : seen_now;
    end
  end

  // R2 R3 R10: after a cold completion only sources seen dropping may be set
  p_cold_subset_r2: assert property (@(posedge clk) disable iff (!por_n)
    cold_done |=> ((rdata[NSRC-1:0] & ~$past(seen_now)) == '0));

  // R4 R6: warm bits present after warm completion, even against a clear
  p_warm_set_r4: assert property (@(posedge clk) disable iff (!por_n)
    (warm_done && !cold_done) |=> ((rdata[NSRC-1:0] & $past(warm_src)) == $past(warm_src)));

  // R5: written ones are clear when nothing sets them
  p_w1c_r5: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !warm_done && !cold_done) |=> ((rdata[NSRC-1:0] & $past(wdata[NSRC-1:0])) == '0));

  // R9: nothing happening keeps the value
  p_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (!cold_done && !warm_done && (!wr_en || wdata[NSRC-1:0] == '0)) |=> $stable(rdata));

  // R8: padding bits read zero
  generate
    if (DW > NSRC) begin : g_pad_chk
      p_pad_zero_r8: assert property (@(posedge clk) disable iff (!por_n)
        rdata[DW-1:NSRC] == '0);
    end
  endgenerate

endmodule

bind reset_cause_reg reset_cause_reg_chk #(.NSRC(NSRC), .DW(DW)) u_chk (.*);

// File: tb/tb_reset_cause_reg.sv
module tb_reset_cause_reg;
  localparam int N  = 4;
  localparam int DW = 8;

  logic          clk = 0;
  logic          por_n = 0;
  logic [N-1:0]  cold_req = '0;
  logic          cold_done = 0;
  logic          warm_done = 0;
  logic [N-1:0]  warm_src = '0;
  logic          wr_en = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  reset_cause_reg #(.NSRC(N), .DW(DW)) dut (.*);

  task automatic check(input string req, input logic [DW-1:0] exp);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp);
    end
  endtask

  task automatic idle();
    cold_done = 0; warm_done = 0; warm_src = '0; wr_en = 0; wdata = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // cold completion with no deassertion -> zero (R10), then warm load
  task automatic load(input logic [N-1:0] v);
    idle(); cold_done = 1; tick();
    idle(); warm_done = 1; warm_src = v; tick();
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: rdata=%h expected=done", rdata);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1", '0);
    por_n = 1;
    tick();
    check("R1", '0);

    // R4 R5 R6 R8: every start value x warm mask x write mask
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 16; w++)
        for (int c = 0; c < 16; c++) begin
          load(N'(s));
          check("R10/R4 load", DW'(s));
          warm_done = (w != 0); warm_src = N'(w);
          wr_en = 1; wdata = {4'hF, 4'(c)};
          tick(); idle();
          check("R5/R6", DW'((s & ~c) | w));
          tick();
          check("R9", DW'((s & ~c) | w));
        end

    // R2 R3: two-stage drop, later set wins, prior contents cleared
    for (int f = 1; f < 16; f++)
      for (int s = 1; s < 16; s++) begin
        load(N'(15 - s));
        cold_req = N'(f | s); tick();
        cold_req = N'(s & ~f); tick();
        cold_req = '0; tick();
        cold_done = 1; tick(); idle();
        check("R2/R3", DW'(((s & ~f) != 0) ? (s & ~f) : (f | s)));
        cold_done = 1; tick(); idle();
        check("R10", '0);
      end

    // R3: drop at the same edge as completion; R7: warm and write ignored
    for (int m = 1; m < 16; m++) begin
      load(4'hF);
      cold_req = 4'b1111; tick();
      cold_req = N'(15 - m);
      cold_done = 1; warm_done = 1; warm_src = 4'hF;
      wr_en = 1; wdata = 8'hFF;
      tick(); idle();
      check("R3/R7", DW'(m));
      cold_req = '0; tick();
    end

    // R9: warm with empty mask and write of zeros keep value
    load(4'b1010);
    warm_done = 1; warm_src = '0; wr_en = 1; wdata = 8'h00; tick(); idle();
    check("R9", 8'h0A);

    // R1 again: power-on reset clears
    por_n = 0; tick();
    check("R1", '0);
    por_n = 1; tick();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule